// File: doc/BRIEF.md
# Multiprocessor UART Receiver with Sticky Receive Status

This block receives asynchronous serial characters on one input line and places each completed character into a single receive buffer. An enable pulse from a baud generator clocks the receiver at sixteen times the bit rate. Each bit value comes from a majority vote of three samples near mid-bit. The frame is a start bit, one to eight data bits sent least significant bit first, an optional address bit, an optional parity bit and a stop bit.

Four status outputs report what happened to received characters. The framing, overrun and parity flags are sticky and clear only through a reset. The wake flag supports two multiprocessor addressing schemes. In one scheme each character carries an extra address bit. In the other, a long idle gap on the line marks the next character as an address. Software reads a character with a one-cycle read strobe. A software-reset input holds the receiver idle and clears all status while it is active.

Top module: `mpu_rx_status`

## Requirements
- R1: With `tick_i` pulsing at 16x the bit rate, a frame holding `char_len_i`+1 data bits (LSB first) is stored right-aligned in `rx_data_o` with the upper bits zero, and `rx_full_o` goes high. A one-cycle `rd_i` pulse clears `rx_full_o`.
- R2: A low level that has ended before the mid-point of the start bit (majority of oversamples 7, 8 and 9) is rejected. It stores no character and changes no output.
- R3: A stop bit that samples low sets `fe_o` and still stores the character. Only one stop bit is sampled, so a new start bit may follow it directly.
- R4: When a character completes while `rx_full_o` is high, `oe_o` is set and the new character replaces the old one in `rx_data_o`.
- R5: With `par_en_i`=1, `pe_o` is set when the parity of the ones in the data bits, the address bit (if present) and the parity bit differs from `par_odd_i`. `par_odd_i`=0 selects even parity and 1 selects odd.
- R6: With `par_en_i`=0 the frame carries no parity bit and `pe_o` never sets.
- R7: `fe_o`, `oe_o` and `pe_o` are unaffected by `rd_i`. They clear only on `rst_ni` low or on `swrst_i` high.
- R8: With `mp_mode_i`=1 (address bit), the frame carries one address bit after the last data bit and before parity or stop. `wake_o` then equals the address bit of the character last stored. `rd_i` clears it.
- R9: With `mp_mode_i`=2 (idle line), the line staying high for 10 bit periods after a completed character sets `wake_o`, and a shorter gap does not. `wake_o` stays set while the first following character is stored. It clears when the second character is stored or on `rd_i`.
- R10: With `mp_mode_i`=0 (or 3), `wake_o` stays 0.
- R11: While `swrst_i` is high the receiver stays idle, frames on the line are ignored, and `rx_full_o`, `fe_o`, `oe_o`, `pe_o` and `wake_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Oversampling enable, 16 pulses per bit period |
| rxd_i | input | 1 | Serial receive line, idles high |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 1 selects odd parity, 0 even |
| char_len_i | input | 3 | Data bits per character minus one |
| mp_mode_i | input | 2 | 0 none, 1 address-bit, 2 idle-line |
| rd_i | input | 1 | Receive buffer read strobe |
| swrst_i | input | 1 | Software reset, active high |
| rx_data_o | output | 8 | Receive buffer |
| rx_full_o | output | 1 | Buffer holds an unread character |
| fe_o | output | 1 | Sticky framing error |
| oe_o | output | 1 | Sticky overrun error |
| pe_o | output | 1 | Sticky parity error |
| wake_o | output | 1 | Wake-up detect |

## Verification
The assertions assume that `par_en_i`, `par_odd_i`, `char_len_i` and `mp_mode_i` change only while the line is idle and no frame is in progress. They also assume that `rd_i` is a single-cycle pulse. The stimulus holds these inputs constant across each frame and changes them only between frames or under software reset. Read pulses are placed well away from character completion, so a read never meets a buffer write in the same cycle.

// File: rtl/mpu_rx_pkg.sv
package mpu_rx_pkg;
  typedef enum logic [1:0] {
    MP_OFF  = 2'd0,
    MP_ADDR = 2'd1,
    MP_IDLE = 2'd2
  } mp_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_ADDR,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic addr;
    logic stop_ok;
    logic par_err;
  } rx_frame_stat_t;
endpackage

// File: rtl/mpu_rx_sampler.sv
module mpu_rx_sampler #(
  parameter int unsigned OSR = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic run_i,
  input  logic tick_i,
  input  logic rxd_i,
  output logic rxd_s_o,
  output logic bit_stb_o,
  output logic bit_val_o
);
  localparam int unsigned CNT_W = $clog2(OSR);
  localparam int unsigned MID   = OSR / 2;
  localparam logic [CNT_W-1:0] S_A   = CNT_W'(MID - 2);
  localparam logic [CNT_W-1:0] S_B   = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] S_C   = CNT_W'(MID);
  localparam logic [CNT_W-1:0] S_END = CNT_W'(OSR - 1);

  logic             rxd_meta, rxd_s;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       votes;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxd_meta <= 1'b1;
      rxd_s    <= 1'b1;
    end else begin
      rxd_meta <= rxd_i;
      rxd_s    <= rxd_meta;
    end
  end

  // cnt+1 is the tick position inside the current bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt   <= '0;
      votes <= '0;
    end else if (hold_i || !run_i) begin
      cnt   <= '0;
      votes <= '0;
    end else if (tick_i) begin
      cnt <= (cnt == S_END) ? '0 : cnt + 1'b1;
      if (cnt == S_A || cnt == S_B) votes <= {votes[0], rxd_s};
    end
  end

  assign rxd_s_o   = rxd_s;
  assign bit_stb_o = tick_i & run_i & ~hold_i & (cnt == S_C);
  assign bit_val_o = (votes[1] & votes[0]) | (votes[1] & rxd_s) | (votes[0] & rxd_s);

  a_r1_stb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |=> !bit_stb_o);
endmodule

// File: rtl/mpu_rx_frame.sv
module mpu_rx_frame
  import mpu_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned LEN_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              tick_i,
  input  logic              rxd_s_i,
  input  logic              bit_stb_i,
  input  logic              bit_val_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              addr_mode_i,
  input  logic [LEN_W-1:0]  len_m1_i,
  output logic              run_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output rx_frame_stat_t    stat_o
);
  rx_state_e         state;
  logic [LEN_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic              acc;
  logic              addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state  <= ST_IDLE;
      idx    <= '0;
      shreg  <= '0;
      acc    <= 1'b0;
      addr_q <= 1'b0;
      done_o <= 1'b0;
      data_o <= '0;
      stat_o <= '0;
    end else if (hold_i) begin
      state  <= ST_IDLE;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: if (tick_i && !rxd_s_i) state <= ST_START;
        ST_START: if (bit_stb_i) begin
          idx    <= '0;
          acc    <= 1'b0;
          addr_q <= 1'b0;
          state  <= bit_val_i ? ST_IDLE : ST_DATA;
        end
        ST_DATA: if (bit_stb_i) begin
          shreg <= {bit_val_i, shreg[DATA_W-1:1]};
          acc   <= acc ^ bit_val_i;
          idx   <= idx + 1'b1;
          if (idx == len_m1_i)
            state <= addr_mode_i ? ST_ADDR : (par_en_i ? ST_PAR : ST_STOP);
        end
        ST_ADDR: if (bit_stb_i) begin
          addr_q <= bit_val_i;
          acc    <= acc ^ bit_val_i;
          state  <= par_en_i ? ST_PAR : ST_STOP;
        end
        ST_PAR: if (bit_stb_i) begin
          acc   <= acc ^ bit_val_i;
          state <= ST_STOP;
        end
        ST_STOP: if (bit_stb_i) begin
          done_o         <= 1'b1;
          data_o         <= shreg >> (LEN_W'(DATA_W - 1) - len_m1_i);
          stat_o.addr    <= addr_q;
          stat_o.stop_ok <= bit_val_i;
          stat_o.par_err <= par_en_i & (acc ^ par_odd_i);
          state          <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign run_o = (state != ST_IDLE);

  a_r11_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !run_o && !done_o);
  a_r1_done_ends_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !run_o);
endmodule

// File: rtl/mpu_rx_idle.sv
module mpu_rx_idle #(
  parameter int unsigned OSR       = 16,
  parameter int unsigned IDLE_BITS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic tick_i,
  input  logic rxd_s_i,
  input  logic run_i,
  input  logic arm_i,
  output logic idle_o
);
  localparam int unsigned LIM   = OSR * IDLE_BITS;
  localparam int unsigned CW    = $clog2(LIM + 1);
  localparam logic [CW-1:0] LAST = CW'(LIM - 1);

  logic          armed;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed  <= 1'b0;
      cnt    <= '0;
      idle_o <= 1'b0;
    end else if (hold_i) begin
      armed  <= 1'b0;
      cnt    <= '0;
      idle_o <= 1'b0;
    end else begin
      idle_o <= 1'b0;
      if (arm_i) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed && tick_i) begin
        if (run_i || !rxd_s_i) begin
          cnt <= '0;
        end else if (cnt == LAST) begin
          idle_o <= 1'b1;
          armed  <= 1'b0;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  a_r9_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> $past(rxd_s_i) && !$past(run_i));
endmodule

// File: rtl/mpu_rx_status.sv
module mpu_rx_status
  import mpu_rx_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned OSR       = 16,
  parameter int unsigned IDLE_BITS = 10,
  localparam int unsigned LEN_W    = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic [LEN_W-1:0]  char_len_i,
  input  logic [1:0]        mp_mode_i,
  input  logic              rd_i,
  input  logic              swrst_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o,
  output logic              fe_o,
  output logic              oe_o,
  output logic              pe_o,
  output logic              wake_o
);
  logic              rxd_s, bit_stb, bit_val, run, chr_done, idle_det;
  logic [DATA_W-1:0] frm_data;
  rx_frame_stat_t    frm_stat;
  logic              addr_seen;
  logic              mode_addr, mode_idle;

  assign mode_addr = (mp_mode_i == MP_ADDR);
  assign mode_idle = (mp_mode_i == MP_IDLE);

  mpu_rx_sampler #(.OSR(OSR)) u_sampler (
    .clk_i, .rst_ni, .hold_i(swrst_i), .run_i(run), .tick_i, .rxd_i,
    .rxd_s_o(rxd_s), .bit_stb_o(bit_stb), .bit_val_o(bit_val)
  );

  mpu_rx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk_i, .rst_ni, .hold_i(swrst_i), .tick_i, .rxd_s_i(rxd_s),
    .bit_stb_i(bit_stb), .bit_val_i(bit_val), .par_en_i, .par_odd_i,
    .addr_mode_i(mode_addr), .len_m1_i(char_len_i),
    .run_o(run), .done_o(chr_done), .data_o(frm_data), .stat_o(frm_stat)
  );

  mpu_rx_idle #(.OSR(OSR), .IDLE_BITS(IDLE_BITS)) u_idle (
    .clk_i, .rst_ni, .hold_i(swrst_i), .tick_i, .rxd_s_i(rxd_s),
    .run_i(run), .arm_i(chr_done), .idle_o(idle_det)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_o <= '0;
      rx_full_o <= 1'b0;
      fe_o      <= 1'b0;
      oe_o      <= 1'b0;
      pe_o      <= 1'b0;
      wake_o    <= 1'b0;
      addr_seen <= 1'b0;
    end else if (swrst_i) begin
      rx_full_o <= 1'b0;
      fe_o      <= 1'b0;
      oe_o      <= 1'b0;
      pe_o      <= 1'b0;
      wake_o    <= 1'b0;
      addr_seen <= 1'b0;
    end else if (chr_done) begin
      rx_data_o <= frm_data;
      rx_full_o <= 1'b1;
      oe_o      <= oe_o | (rx_full_o & ~rd_i);
      fe_o      <= fe_o | ~frm_stat.stop_ok;
      pe_o      <= pe_o | frm_stat.par_err;
      if (mode_addr) begin
        wake_o <= frm_stat.addr;
      end else if (mode_idle) begin
        // first character after idle is the address: keep wake over it
        if (wake_o && !addr_seen) addr_seen <= 1'b1;
        else                      wake_o    <= 1'b0;
      end else begin
        wake_o <= 1'b0;
      end
    end else if (idle_det && mode_idle) begin
      wake_o    <= 1'b1;
      addr_seen <= 1'b0;
    end else if (rd_i) begin
      rx_full_o <= 1'b0;
      wake_o    <= 1'b0;
    end
  end

  a_r7_fe_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fe_o && !swrst_i) |=> fe_o);
  a_r7_oe_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && !swrst_i) |=> oe_o);
  a_r7_pe_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_o && !swrst_i) |=> pe_o);
  a_r4_oe_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> $past(rx_full_o));
  a_r6_pe_needs_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pe_o) |-> $past(par_en_i));
  a_r11_swrst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_i |=> !(rx_full_o || fe_o || oe_o || pe_o || wake_o));
  a_r8_read_clears_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !chr_done && !idle_det && !swrst_i) |=> !wake_o && !rx_full_o);
  a_r10_no_wake_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> ($past(mp_mode_i) == MP_ADDR || $past(mp_mode_i) == MP_IDLE));
endmodule

// File: tb/mpu_rx_status_tb.sv
`timescale 1ns/1ps
module mpu_rx_status_tb;
  localparam int BIT = 64;  // 16 ticks x 4 clocks

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick;
  logic       rxd = 1'b1;
  logic       par_en = 1'b0, par_odd = 1'b0;
  logic [2:0] char_len = 3'd7;
  logic [1:0] mp_mode = 2'd0;
  logic       rd = 1'b0, swrst = 1'b0;
  logic [7:0] rx_data;
  logic       rx_full, fe, oe, pe, wake;

  int  checks = 0, errors = 0;
  logic cmp_en = 1'b0;
  string cur_req = "R1";

  logic [7:0] exp_data = '0;
  logic exp_full = 0, exp_fe = 0, exp_oe = 0, exp_pe = 0, exp_wake = 0, exp_seen = 0;

  int div = 0;
  always #4 clk = ~clk;
  always @(negedge clk) div <= (div == 3) ? 0 : div + 1;
  assign tick = (div == 0);

  mpu_rx_status u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .rxd_i(rxd),
    .par_en_i(par_en), .par_odd_i(par_odd), .char_len_i(char_len),
    .mp_mode_i(mp_mode), .rd_i(rd), .swrst_i(swrst),
    .rx_data_o(rx_data), .rx_full_o(rx_full), .fe_o(fe), .oe_o(oe),
    .pe_o(pe), .wake_o(wake)
  );

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_en) begin
    chk("rx_full", rx_full, exp_full);
    chk("fe", fe, exp_fe);
    chk("oe", oe, exp_oe);
    chk("pe", pe, exp_pe);
    chk("wake", wake, exp_wake);
    if (exp_full) chk("rx_data", rx_data, exp_data);
  end

  task automatic settle(int n);
    cmp_en = 1'b1;
    repeat (n) @(negedge clk);
    cmp_en = 1'b0;
  endtask

  task automatic hold_line(int bits);
    rxd = 1'b1;
    repeat (bits * BIT) @(negedge clk);
  endtask

  task automatic send(logic [7:0] d, logic a, logic flip, logic stop_hi, int gap, logic ignored);
    int len = int'(char_len) + 1;
    logic [7:0] mask = 8'((9'h1 << len) - 1);
    logic ones = ^(d & mask) ^ ((mp_mode == 2'd1) ? a : 1'b0);
    logic p = (par_odd ? ~ones : ones) ^ flip;
    rxd = 1'b0; repeat (BIT) @(negedge clk);
    for (int i = 0; i < len; i++) begin rxd = d[i]; repeat (BIT) @(negedge clk); end
    if (mp_mode == 2'd1) begin rxd = a; repeat (BIT) @(negedge clk); end
    if (par_en) begin rxd = p; repeat (BIT) @(negedge clk); end
    if (stop_hi) begin rxd = 1'b1; repeat (BIT) @(negedge clk); end
    else begin
      rxd = 1'b0; repeat (48) @(negedge clk);
      rxd = 1'b1; repeat (BIT - 48) @(negedge clk);
    end
    if (!ignored) begin
      exp_oe   = exp_oe | exp_full;
      exp_full = 1'b1;
      exp_data = d & mask;
      if (!stop_hi) exp_fe = 1'b1;
      if (par_en && flip) exp_pe = 1'b1;
      if (mp_mode == 2'd1) exp_wake = a;
      else if (mp_mode == 2'd2) begin
        if (exp_wake && !exp_seen) exp_seen = 1'b1;
        else exp_wake = 1'b0;
      end else exp_wake = 1'b0;
    end
    hold_line(gap);
  endtask

  task automatic rd_pulse();
    rd = 1'b1; @(negedge clk);
    rd = 1'b0; @(negedge clk);
    exp_full = 1'b0;
    exp_wake = 1'b0;
  endtask

  task automatic sw_reset();
    swrst = 1'b1;
    exp_full = 0; exp_fe = 0; exp_oe = 0; exp_pe = 0; exp_wake = 0; exp_seen = 0;
    repeat (2) @(negedge clk);
    cur_req = "R11";
    settle(4);
    cmp_en = 1'b1;  // frame during reset must change nothing
    send(8'hC3, 1'b0, 1'b1, 1'b0, 1, 1'b1);
    cmp_en = 1'b0;
    swrst = 1'b0;
    @(negedge clk);
    settle(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    cur_req = "R1"; settle(8);                        // reset state

    // R1: full-length and short characters, read strobe
    send(8'hA5, 0, 0, 1, 1, 0); settle(8);
    rd_pulse(); settle(4);
    char_len = 3'd4;
    send(8'h33, 0, 0, 1, 1, 0); settle(8);            // expect 0x13
    rd_pulse(); settle(4);
    char_len = 3'd7;

    // R2: glitch shorter than half a bit
    cur_req = "R2";
    rxd = 1'b0; repeat (16) @(negedge clk);
    hold_line(2); settle(8);

    // R5: even parity good then bad, R7: read keeps pe
    par_en = 1'b1; par_odd = 1'b0; cur_req = "R5";
    send(8'h5A, 0, 0, 1, 1, 0); settle(8); rd_pulse();
    send(8'h5B, 0, 1, 1, 1, 0); settle(8);
    cur_req = "R7"; rd_pulse(); settle(8);
    sw_reset();
    cur_req = "R5"; par_odd = 1'b1;
    send(8'h07, 0, 0, 1, 1, 0); settle(8); rd_pulse();
    // R6: parity disabled
    cur_req = "R6"; par_en = 1'b0;
    send(8'h01, 0, 1, 1, 1, 0); settle(8); rd_pulse(); settle(4);

    // R3: low stop bit, R7: read keeps fe
    cur_req = "R3";
    send(8'h3C, 0, 0, 0, 2, 0); settle(8);
    cur_req = "R7"; rd_pulse(); settle(8);
    sw_reset();

    // R3 / R4: back-to-back frames, second overruns the first
    cur_req = "R4";
    send(8'h11, 0, 0, 1, 0, 0);
    send(8'h22, 0, 0, 1, 1, 0); settle(8);
    cur_req = "R7"; rd_pulse(); settle(8);
    sw_reset();

    // R8: address-bit mode with odd parity
    cur_req = "R8"; mp_mode = 2'd1; par_en = 1'b1; par_odd = 1'b1;
    send(8'h3C, 1, 0, 1, 1, 0); settle(8);
    rd_pulse(); settle(8);
    send(8'h3C, 1, 0, 1, 1, 0); settle(8);
    send(8'h11, 0, 0, 1, 1, 0); settle(8);            // wake drops, oe set
    sw_reset();
    // R5: address bit is counted in parity
    cur_req = "R5"; par_odd = 1'b0;
    send(8'h01, 1, 0, 1, 1, 0); settle(8); rd_pulse();
    send(8'h01, 1, 1, 1, 1, 0); settle(8);            // parity left out address bit
    sw_reset();

    // R9: idle-line mode
    cur_req = "R9"; mp_mode = 2'd2; par_en = 1'b0;
    send(8'h40, 0, 0, 1, 6, 0); settle(8);            // short gap: no wake
    hold_line(6); exp_wake = 1'b1; exp_seen = 1'b0; settle(8);
    send(8'h81, 0, 0, 1, 1, 0); settle(8);            // address char keeps wake
    send(8'h42, 0, 0, 1, 1, 0); settle(8);            // next char clears it
    rd_pulse(); settle(4);
    hold_line(12); exp_wake = 1'b1; exp_seen = 1'b0; settle(8);
    rd_pulse(); settle(8);
    sw_reset();

    // R10: no multiprocessor mode
    cur_req = "R10"; mp_mode = 2'd0;
    send(8'h55, 0, 0, 1, 12, 0); settle(8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule